// File: doc/BRIEF.md
# ADC Sample Offset and Format Stage

This stage sits between a 12-bit converter core and its output serializer. Each raw sample arrives in offset-binary coding together with a strobe. The stage adds a signed 8-bit trim, counted in LSBs, to the sample. When the sum falls outside the 12-bit range it is clamped to the nearest end rather than wrapped. The clamped value is then coded either as offset binary or as twos complement, and every bit of the word can be complemented before the result is registered.

The trim, the format select and the invert control are sampled in the same cycle as the sample strobe. A configuration change therefore reaches only samples that arrive with or after it. The output word and its valid flag come from one register stage. Between samples the output word holds its last value.

Top module: `adc_fmt_stage`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_word` is 0x000.
- R2: `out_valid` is 1 in the cycle after a cycle with `smp_valid` high, and 0 in the cycle after a cycle with `smp_valid` low.
- R3: With `fmt_twos`=0 and `inv_en`=0, `out_word` equals `smp_raw` plus the twos-complement value of `trim` (range -128..+127), when that sum lies in 0..4095.
- R4: A sum above 4095 is clamped to 4095, which is 0xFFF in offset binary before any format change or inversion.
- R5: A sum below 0 is clamped to 0, which is 0x000 in offset binary before any format change or inversion.
- R6: With `fmt_twos`=1, bit 11 of the clamped offset-binary value is complemented, so that 0 becomes 0x800 and 4095 becomes 0x7FF.
- R7: With `inv_en`=1, all 12 bits are complemented after the format step.
- R8: While `smp_valid` is 0, `out_word` keeps its value, and changes on `smp_raw`, `trim`, `fmt_twos` or `inv_en` do not change it.
- R9: Each output word uses the `trim`, `fmt_twos` and `inv_en` values present in the same cycle as its sample strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Raw sample strobe |
| smp_raw | input | 12 | Raw sample, offset binary |
| trim | input | 8 | Signed offset trim in LSBs |
| fmt_twos | input | 1 | 0 = offset binary, 1 = twos complement |
| inv_en | input | 1 | Complement the output word |
| out_valid | output | 1 | Output word valid |
| out_word | output | 12 | Formatted, registered sample |

## Verification
The assertions check on every cycle that the valid flag follows the strobe by one clock. They also check that the word is stable between samples, that clamping never moves the value against the sign of the trim, and that the format and invert steps produce the expected bit relation between registered stages. Only the bench sweeps can show the exact arithmetic values over every raw code and the clamp points. The same is true of the mapping of the clamp ends into each output coding, and of the fact that configuration changed together with a strobe takes effect on that very sample.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
    localparam int SMP_W  = 12;
    localparam int TRIM_W = 8;

    typedef struct packed {
        logic             vld;
        logic [SMP_W-1:0] word;
    } out_state_t;
endpackage

// File: rtl/adc_trim_sat.sv
module adc_trim_sat #(
    parameter int SMP_W  = 12,
    parameter int TRIM_W = 8
) (
    input  logic [SMP_W-1:0]  raw_ob,
    input  logic [TRIM_W-1:0] trim_s,
    output logic [SMP_W-1:0]  sat_ob
);
    localparam int SUM_W = SMP_W + 2;
    localparam logic signed [SUM_W-1:0] TOP_CODE = SUM_W'((1 << SMP_W) - 1);

    logic signed [SUM_W-1:0] raw_ext;
    logic signed [SUM_W-1:0] trim_ext;
    logic signed [SUM_W-1:0] sum_s;

    always_comb begin
        raw_ext  = signed'({2'b00, raw_ob});
        trim_ext = signed'({{(SUM_W-TRIM_W){trim_s[TRIM_W-1]}}, trim_s});
        sum_s    = raw_ext + trim_ext;
        if (sum_s < 0) begin
            sat_ob = '0;                       // R5 lower clamp
        end else if (sum_s > TOP_CODE) begin
            sat_ob = '1;                       // R4 upper clamp
        end else begin
            sat_ob = sum_s[SMP_W-1:0];
        end
    end
endmodule

// File: rtl/adc_code_map.sv
module adc_code_map #(
    parameter int SMP_W = 12
) (
    input  logic [SMP_W-1:0] sat_ob,
    input  logic             fmt_twos,
    input  logic             inv_en,
    output logic [SMP_W-1:0] fmt_word,
    output logic [SMP_W-1:0] coded
);
    always_comb begin
        fmt_word          = sat_ob;
        fmt_word[SMP_W-1] = sat_ob[SMP_W-1] ^ fmt_twos;   // R6
    end

    for (genvar b = 0; b < SMP_W; b++) begin : g_inv
        assign coded[b] = fmt_word[b] ^ inv_en;           // R7
    end
endmodule

// File: rtl/adc_fmt_stage.sv
module adc_fmt_stage
    import adc_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_raw,
    input  logic [TRIM_W-1:0] trim,
    input  logic              fmt_twos,
    input  logic              inv_en,
    output logic              out_valid,
    output logic [SMP_W-1:0]  out_word
);
    logic [SMP_W-1:0] sat_ob;
    logic [SMP_W-1:0] fmt_word;
    logic [SMP_W-1:0] coded;
    out_state_t       st_d, st_q;

    adc_trim_sat #(.SMP_W(SMP_W), .TRIM_W(TRIM_W)) u_sat (
        .raw_ob (smp_raw),
        .trim_s (trim),
        .sat_ob (sat_ob)
    );

    adc_code_map #(.SMP_W(SMP_W)) u_map (
        .sat_ob   (sat_ob),
        .fmt_twos (fmt_twos),
        .inv_en   (inv_en),
        .fmt_word (fmt_word),
        .coded    (coded)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = smp_valid;
        if (smp_valid) begin
            st_d.word = coded;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_word  = st_q.word;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);
    a_r8_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(out_word));
    a_r4_trim_up_never_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !trim[TRIM_W-1]) |-> (sat_ob >= smp_raw));
    a_r5_trim_down_never_higher: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && trim[TRIM_W-1]) |-> (sat_ob <= smp_raw));
    a_r6_msb_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !inv_en) |=>
            (out_word[SMP_W-1] == ($past(sat_ob[SMP_W-1]) ^ $past(fmt_twos))));
    a_r7_full_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && inv_en) |=> (out_word == ~$past(fmt_word)));
endmodule

// File: tb/sim_adc_fmt_stage.sv
module sim_adc_fmt_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_raw = '0;
    logic [7:0]  trim = '0;
    logic        fmt_twos = 1'b0;
    logic        inv_en = 1'b0;
    logic        out_valid;
    logic [11:0] out_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    adc_fmt_stage u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_raw(smp_raw),
        .trim(trim), .fmt_twos(fmt_twos), .inv_en(inv_en),
        .out_valid(out_valid), .out_word(out_word)
    );

    function automatic int expect_word(int raw, int t, bit f, bit inv);
        int v = raw + t;
        if (v > 4095) v = 4095;
        if (v < 0)    v = 0;
        if (f)   v = v ^ 2048;
        if (inv) v = v ^ 4095;
        return v;
    endfunction

    function automatic string tag_for(int raw, int t, bit f, bit inv);
        if (raw + t > 4095) return "R4";
        if (raw + t < 0)    return "R5";
        if (inv)            return "R7";
        if (f)              return "R6";
        return "R3";
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%03h expected=0x%03h", req, act, exp);
        end
    endtask

    // drive one sample at a falling edge, check it at the next falling edge
    task automatic one_sample(int raw, int t, bit f, bit inv);
        smp_valid = 1'b1;
        smp_raw   = 12'(raw);
        trim      = 8'(t);
        fmt_twos  = f;
        inv_en    = inv;
        @(negedge clk);
        check("R2", int'(out_valid), 1);
        check({tag_for(raw, t, f, inv), "/R9"}, int'(out_word), expect_word(raw, t, f, inv));
    endtask

    initial begin
        int trims[6] = '{0, 127, -128, -1, 1, 37};
        int last;
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_word), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", int'(out_valid), 0);

        // full raw sweep per trim, configuration cycling sample by sample (R9)
        foreach (trims[i]) begin
            for (int r = 0; r < 4096; r++) begin
                one_sample(r, trims[i], r[0] ^ i[0], r[1]);
            end
        end

        // clamp ends in every coding: R4 and R5
        for (int c = 0; c < 4; c++) begin
            one_sample(4095, 127, c[0], c[1]);
            one_sample(0, -128, c[0], c[1]);
            one_sample(3968, 127, c[0], c[1]);
            one_sample(128, -128, c[0], c[1]);
        end
        one_sample(2048, 0, 1'b0, 1'b0);
        check("R3", int'(out_word), 2048);
        one_sample(0, -128, 1'b1, 1'b0);
        check("R6", int'(out_word), 12'h800);
        one_sample(4095, 5, 1'b1, 1'b0);
        check("R6", int'(out_word), 12'h7FF);

        // hold while strobe is low, with inputs and configuration changing (R8)
        one_sample(1000, 10, 1'b0, 1'b0);
        last = int'(out_word);
        smp_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            smp_raw  = 12'(k * 700 + 3);
            trim     = 8'(k * 50 - 100);
            fmt_twos = k[0];
            inv_en   = ~k[1];
            @(negedge clk);
            check("R8", int'(out_word), last);
            check("R2", int'(out_valid), 0);
        end
        one_sample(1000, 10, 1'b0, 1'b0);
        check("R8", int'(out_word), 1010);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule